// File: doc/BRIEF.md
# Two-level interrupt status aggregator

This block collects event pulses from a power-management companion chip and presents them to a host as one active-low interrupt request. There are nine sub-status registers of eight bits each. Every bit latches its event until the host clears it. Each sub-status register has its own sub-mask register. The unmasked bits of each sub-status register are ORed into one bit of an eight-bit main status register. One main bit, the charger group, gathers two sub-registers. A main mask register then gates each main bit onto the interrupt line.

The host works through a byte-wide register port with an address, write data, a write strobe and a combinational read-data output. To clear a status bit, the host writes a 1 to that bit at the sub-status register's own address. Four GPIO pins feed the low four bits of sub-register 7. Each pin has its own type register, and the code in it selects rising-edge, falling-edge, high-level or low-level detection, or turns detection off. Event inputs are synchronous to the block clock.

Top module: `pmu_irq_aggr`

## Requirements
- R1: After reset, every sub-status register and the main status register (address 0x20) read 0x00. The sub-mask registers (0x10+k) and the main mask register (0x21) read 0xFF. The GPIO type registers (0x30+2i) read 0x00, and irq_n_o is high.
- R2: A one-cycle pulse on evt_i[8k+b] sets bit b of sub-status register k (address k, k = 0..8) at the next clock edge. The bit then stays set until it is acknowledged.
- R3: A write to sub-status address k clears exactly those bits written as 1. Bits written as 0 are unchanged.
- R4: If an event for a bit arrives in the same cycle as a write-1 acknowledge of that bit, the bit stays set.
- R5: Main status bit j reads as the OR of the bits of its sub-register(s) whose sub-mask bit is 0. Sub-registers 0–3 feed main bits 0–3, and sub-registers 6, 7 and 8 feed main bits 5, 6 and 7.
- R6: Main status bit 4 is the OR of the unmasked bits of both sub-register 4 and sub-register 5.
- R7: Writes to the main status address change no status bit.
- R8: irq_n_o is low exactly when some main status bit is 1 and its main mask bit is 0.
- R9: Pin i's type register at 0x30+2i selects rising-edge detection with 0x20 and falling-edge detection with 0x10. A detected edge sets bit i of sub-register 7, and an unchanged pin level sets nothing.
- R10: Type 0x40 (level high) and type 0x50 (level low) set the bit on every cycle the level holds. While the level holds, an acknowledge leaves the bit set.
- R11: Any other type value, including 0x00, disables detection on that pin. The evt_i inputs for the low four bits of sub-register 7 are ignored, while its upper four bits latch events as usual.
- R12: Reads of addresses that map to no register return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 72 | Event inputs, bit 8k+b feeds sub-status register k bit b |
| gpio_pin_i | input | 4 | Synchronous GPIO pin levels |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that event inputs and GPIO levels are synchronous to the clock. They also assume that a register write lasts exactly one cycle and that no event is active while reset is held. The properties on latching and clearing are only sound under those conditions. The bench meets them by changing every input on the falling edge only and by keeping evt_i at zero through reset. It also drives each write as a single-cycle strobe, including in the cycle where an event and an acknowledge collide.

// File: rtl/pmu_irq_aggr.sv
`timescale 1ns/1ps
module pmu_irq_aggr #(
  parameter int NSUB = 9,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter int NGPIO = 4,
  parameter int GPIO_SUB = 7,
  parameter int PAIR_GRP = 4,
  parameter logic [7:0] MASK_BASE = 8'h10,
  parameter logic [7:0] MAIN_ADDR = 8'h20,
  parameter logic [7:0] MMASK_ADDR = 8'h21,
  parameter logic [7:0] TYPE_BASE = 8'h30,
  parameter logic [7:0] CODE_RISE = 8'h20,
  parameter logic [7:0] CODE_FALL = 8'h10,
  parameter logic [7:0] CODE_HIGH = 8'h40,
  parameter logic [7:0] CODE_LOW = 8'h50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSUB*DW-1:0] evt_i,
  input  logic [NGPIO-1:0]   gpio_pin_i,
  input  logic [AW-1:0]      reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic               reg_we,
  output logic [DW-1:0]      reg_rdata,
  output logic               irq_n_o
);
  localparam int EW = NSUB * DW;
  localparam int TW = NGPIO * DW;

  logic [EW-1:0]    stat_flat, mask_flat, set_flat, ack_flat;
  logic [TW-1:0]    type_flat;
  logic [DW-1:0]    mmask_q, main_stat;
  logic [NGPIO-1:0] pin_q, gpio_hit;

  for (genvar g = 0; g < NGPIO; g++) begin : g_pin
    logic [DW-1:0] code;
    assign code = type_flat[g*DW +: DW];
    assign gpio_hit[g] = ((code == CODE_RISE) &&  gpio_pin_i[g] && !pin_q[g]) ||
                         ((code == CODE_FALL) && !gpio_pin_i[g] &&  pin_q[g]) ||
                         ((code == CODE_HIGH) &&  gpio_pin_i[g]) ||
                         ((code == CODE_LOW)  && !gpio_pin_i[g]);
  end

  for (genvar k = 0; k < NSUB; k++) begin : g_sub
    if (k == GPIO_SUB) begin : g_gp
      assign set_flat[k*DW +: DW] = {evt_i[k*DW+NGPIO +: DW-NGPIO], gpio_hit};
    end else begin : g_ev
      assign set_flat[k*DW +: DW] = evt_i[k*DW +: DW];
    end
    assign ack_flat[k*DW +: DW] = (reg_we && reg_addr == AW'(k)) ? reg_wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_flat <= '0;
      mask_flat <= '1;
      mmask_q   <= '1;
      type_flat <= '0;
      pin_q     <= '0;
    end else begin
      pin_q     <= gpio_pin_i;
      stat_flat <= (stat_flat & ~ack_flat) | set_flat;
      for (int k = 0; k < NSUB; k++)
        if (reg_we && reg_addr == MASK_BASE + AW'(k))
          mask_flat[k*DW +: DW] <= reg_wdata;
      if (reg_we && reg_addr == MMASK_ADDR)
        mmask_q <= reg_wdata;
      for (int g = 0; g < NGPIO; g++)
        if (reg_we && reg_addr == TYPE_BASE + AW'(2*g))
          type_flat[g*DW +: DW] <= reg_wdata;
    end
  end

  always_comb begin
    main_stat = '0;
    for (int k = 0; k < NSUB; k++) begin
      if (k <= PAIR_GRP)
        main_stat[k] = main_stat[k] | (|(stat_flat[k*DW +: DW] & ~mask_flat[k*DW +: DW]));
      else
        main_stat[k-1] = main_stat[k-1] | (|(stat_flat[k*DW +: DW] & ~mask_flat[k*DW +: DW]));
    end
  end

  assign irq_n_o = ~|(main_stat & ~mmask_q);

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NSUB; k++) begin
      if (reg_addr == AW'(k))             reg_rdata = stat_flat[k*DW +: DW];
      if (reg_addr == MASK_BASE + AW'(k)) reg_rdata = mask_flat[k*DW +: DW];
    end
    for (int g = 0; g < NGPIO; g++)
      if (reg_addr == TYPE_BASE + AW'(2*g)) reg_rdata = type_flat[g*DW +: DW];
    if (reg_addr == MAIN_ADDR)  reg_rdata = main_stat;
    if (reg_addr == MMASK_ADDR) reg_rdata = mmask_q;
  end
endmodule

// File: rtl/pmu_irq_aggr_chk.sv
`timescale 1ns/1ps
module pmu_irq_aggr_chk #(
  parameter int NSUB = 9,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [7:0] MAIN_ADDR = 8'h20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [AW-1:0]      reg_addr,
  input logic [DW-1:0]      reg_wdata,
  input logic               irq_n_o,
  input logic [NSUB*DW-1:0] stat_flat,
  input logic [NSUB*DW-1:0] set_flat,
  input logic [DW-1:0]      mmask_q
);
  logic [NSUB*DW-1:0] ack_c;
  for (genvar k = 0; k < NSUB; k++) begin : g_ack
    assign ack_c[k*DW +: DW] = (reg_we && reg_addr == AW'(k)) ? reg_wdata : '0;
  end

  AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_flat) |=> ((stat_flat & $past(set_flat)) == $past(set_flat))); // R2
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((stat_flat & ~$past(stat_flat) & ~$past(set_flat)) == '0)); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_c & ~set_flat)) |=> ((stat_flat & $past(ack_c & ~set_flat)) == '0)); // R3
  AST_EVENT_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_c & set_flat)) |=> ((stat_flat & $past(ack_c & set_flat)) == $past(ack_c & set_flat))); // R4
  AST_MAIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == MAIN_ADDR) |=> (stat_flat == ($past(stat_flat) | $past(set_flat)))); // R7
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mmask_q == '1) |-> irq_n_o); // R8
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n_o |-> (|stat_flat)); // R8
endmodule

bind pmu_irq_aggr pmu_irq_aggr_chk #(.NSUB(NSUB), .DW(DW), .AW(AW), .MAIN_ADDR(MAIN_ADDR)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .irq_n_o(irq_n_o), .stat_flat(stat_flat), .set_flat(set_flat), .mmask_q(mmask_q)
);

// File: tb/pmu_irq_aggr_tb_top.sv
`timescale 1ns/1ps
module pmu_irq_aggr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [71:0] evt = '0;
  logic [3:0]  pins = '0;
  logic [7:0]  addr = '0, wdata = '0, rdata;
  logic        we = 1'b0;
  logic        irq_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmu_irq_aggr dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .gpio_pin_i(pins),
    .reg_addr(addr), .reg_wdata(wdata), .reg_we(we),
    .reg_rdata(rdata), .irq_n_o(irq_n)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic irq(string req, logic exp);
    #1;
    chk(req, {7'd0, irq_n}, {7'd0, exp});
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic pulse(int k, int b);
    @(negedge clk); evt[k*8+b] = 1'b1;
    @(negedge clk); evt = '0;
  endtask

  task automatic setpin(logic [3:0] p);
    @(negedge clk); pins = p;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 9; k++) rd("R1", 8'(k), 8'h00);
    for (int k = 0; k < 9; k++) rd("R1", 8'h10 + 8'(k), 8'hFF);
    rd("R1", 8'h20, 8'h00);
    rd("R1", 8'h21, 8'hFF);
    for (int g = 0; g < 4; g++) rd("R1", 8'h30 + 8'(2*g), 8'h00);
    irq("R1", 1'b1);
  endtask

  task automatic t_latch_ack;
    @(negedge clk); evt[2*8+1] = 1'b1; evt[2*8+6] = 1'b1;
    @(negedge clk); evt = '0;
    rd("R2", 8'h02, 8'h42);
    repeat (3) @(negedge clk);
    rd("R2", 8'h02, 8'h42);
    wr(8'h02, 8'h02);
    rd("R3", 8'h02, 8'h40);
    wr(8'h02, 8'h40);
    rd("R3", 8'h02, 8'h00);
  endtask

  task automatic t_collision;
    @(negedge clk); evt[1*8+0] = 1'b1; we = 1'b1; addr = 8'h01; wdata = 8'h01;
    @(negedge clk); evt = '0; we = 1'b0;
    rd("R4", 8'h01, 8'h01);
    wr(8'h01, 8'h01);
    rd("R4", 8'h01, 8'h00);
  endtask

  task automatic t_main;
    pulse(3, 0);
    rd("R5", 8'h20, 8'h00);
    wr(8'h13, 8'hFE);
    rd("R5", 8'h20, 8'h08);
    irq("R8", 1'b1);
    wr(8'h21, 8'hF7);
    irq("R8", 1'b0);
    wr(8'h20, 8'hFF);
    rd("R7", 8'h20, 8'h08);
    rd("R7", 8'h03, 8'h01);
    wr(8'h03, 8'h01);
    irq("R8", 1'b1);
    rd("R5", 8'h20, 8'h00);
  endtask

  task automatic t_charger;
    wr(8'h15, 8'h7F);
    wr(8'h14, 8'hFE);
    pulse(5, 7);
    rd("R6", 8'h20, 8'h10);
    pulse(4, 0);
    wr(8'h05, 8'h80);
    rd("R6", 8'h20, 8'h10);
    wr(8'h04, 8'h01);
    rd("R6", 8'h20, 8'h00);
  endtask

  task automatic t_gpio_edge;
    wr(8'h32, 8'h20);
    setpin(4'b0010);
    rd("R9", 8'h07, 8'h02);
    wr(8'h07, 8'h02);
    rd("R9", 8'h07, 8'h00);
    wr(8'h34, 8'h10);
    setpin(4'b0110);
    rd("R9", 8'h07, 8'h00);
    setpin(4'b0010);
    rd("R9", 8'h07, 8'h04);
    wr(8'h07, 8'h04);
    setpin(4'b0000);
    rd("R9", 8'h07, 8'h00);
  endtask

  task automatic t_gpio_level;
    wr(8'h30, 8'h40);
    rd("R10", 8'h07, 8'h00);
    setpin(4'b0001);
    rd("R10", 8'h07, 8'h01);
    wr(8'h07, 8'h01);
    rd("R10", 8'h07, 8'h01);
    setpin(4'b0000);
    wr(8'h07, 8'h01);
    rd("R10", 8'h07, 8'h00);
    wr(8'h36, 8'h50);
    @(negedge clk);
    rd("R10", 8'h07, 8'h08);
    setpin(4'b1000);
    wr(8'h07, 8'h08);
    rd("R10", 8'h07, 8'h00);
  endtask

  task automatic t_gpio_off;
    wr(8'h30, 8'h00);
    wr(8'h32, 8'h30);
    wr(8'h34, 8'h00);
    wr(8'h36, 8'h00);
    setpin(4'b1111);
    setpin(4'b0000);
    rd("R11", 8'h07, 8'h00);
    @(negedge clk); evt[59:56] = 4'hF;
    @(negedge clk); evt = '0;
    rd("R11", 8'h07, 8'h00);
    pulse(7, 5);
    rd("R11", 8'h07, 8'h20);
    wr(8'h07, 8'h20);
  endtask

  task automatic t_unmapped;
    rd("R12", 8'h09, 8'h00);
    rd("R12", 8'h31, 8'h00);
    rd("R12", 8'h40, 8'h00);
    rd("R12", 8'hFF, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_latch_ack;
    t_collision;
    t_main;
    t_charger;
    t_gpio_edge;
    t_gpio_level;
    t_gpio_off;
    t_unmapped;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule